// File: doc/BRIEF.md
# Edge Change-Detection Interrupt Controller

This block watches a bank of already-filtered digital inputs and reports transitions on them. Software chooses, for each channel, whether a rising transition, a falling transition, or both count as an event. Two global switches in the control register arm rising and falling detection as a whole. The first event sets a sticky edge flag. An event that arrives while that flag is still set also sets a sticky overflow flag. Software clears either flag by writing ones to a clear register.

A single level interrupt line is raised from these flags. It is gated by per-source enables and by a master enable. A status byte shows the two flags together with a master bit. Software should act only when the master bit and the edge flag are both set.

All configuration and status go through a byte-wide register port: a write strobe, an address and write data, with read data decoded combinationally from the address.

Top module: `edge_notify_ctrl`

## Requirements
- R1: After reset, the status byte (offset 0x04), the control byte (offset 0x05), every mask byte and `irq` all read 0.
- R2: A 0-to-1 change on a channel whose rise-mask bit is set, while control bit 3 (rise arm) is 1, sets status bit 0 (edge). The new value is visible one clock edge after the input changes.
- R3: A 1-to-0 change on a channel whose fall-mask bit is set, while control bit 4 (fall arm) is 1, sets status bit 0 one clock edge after the input changes.
- R4: A transition does not alter the status byte if its channel's mask bit for that direction is clear, or if the matching arm bit is 0.
- R5: An event that is detected while status bit 0 is already set also sets status bit 1 (overflow).
- R6: A write to offset 0x00 clears the edge bit when data bit 3 is 1, and clears the overflow bit when data bit 2 is 1. Each bit is cleared independently of the other.
- R7: If an event and an edge-clear write reach the same clock edge, the edge bit ends up set.
- R8: Status bit 2 equals control bit 2 (master enable) AND ((edge AND control bit 0) OR (overflow AND control bit 1)). `irq` always equals status bit 2.
- R9: Writing 0 to the control byte drops `irq` and status bit 2 on the next edge. The edge and overflow flags keep their values.
- R10: The control byte reads back its bits 4:0. Rise-mask bytes sit at 0x08, 0x09 and 0x0A, and fall-mask bytes at 0x0C, 0x0D and 0x0E. Byte k holds channels 8k to 8k+7, with bit j for channel 8k+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | CH (24) | Filtered channel inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| irq | output | 1 | Level interrupt, equals master status |

## Verification
The hardest case to produce from the ports is an event and an edge-clear write landing on the same clock edge. In that case the event must win. The bench first raises a fall-armed channel and leaves it high for a cycle. It then lowers that channel at the very negative edge where it asserts the clear write, so both reach the design at one rising edge. Overflow needs two separate events with no clear between them. The bench produces it by toggling one fall-masked channel twice, and then clears the edge and overflow bits one at a time.

// File: rtl/edc_pkg.sv
package edc_pkg;
  localparam int AW = 5;

  localparam logic [AW-1:0] OFF_CLEAR = 5'h00;
  localparam logic [AW-1:0] OFF_STAT  = 5'h04;
  localparam logic [AW-1:0] OFF_CTRL  = 5'h05;
  localparam logic [AW-1:0] OFF_RISE  = 5'h08;
  localparam logic [AW-1:0] OFF_FALL  = 5'h0C;

  localparam int CLR_EDGE_BIT = 3;
  localparam int CLR_OVF_BIT  = 2;

  // Packed order matches control bits 4..0
  typedef struct packed {
    logic fall_arm;
    logic rise_arm;
    logic master_en;
    logic ovf_ie;
    logic edge_ie;
  } ctrl_t;
endpackage

// File: rtl/edc_regs.sv
module edc_regs
  import edc_pkg::*;
#(
  parameter int CH = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  input  logic [7:0]      status_byte,
  output ctrl_t           ctrl,
  output logic [CH-1:0]   rise_mask,
  output logic [CH-1:0]   fall_mask,
  output logic            clr_edge,
  output logic            clr_ovf,
  output logic [7:0]      rdata
);
  localparam int NBYTES = (CH + 7) / 8;

  ctrl_t                  ctrl_q, ctrl_d;
  logic [NBYTES-1:0][7:0] rise_q, rise_d;
  logic [NBYTES-1:0][7:0] fall_q, fall_d;
  logic [NBYTES-1:0]      rise_we, fall_we;
  logic                   ctrl_we;

  assign ctrl_we = wr_en && (addr == OFF_CTRL);

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte_we
      assign rise_we[b] = wr_en && (addr == OFF_RISE + AW'(b));
      assign fall_we[b] = wr_en && (addr == OFF_FALL + AW'(b));
    end
  endgenerate

  // Next-state
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_t'(wdata[4:0]);
    rise_d = rise_q;
    fall_d = fall_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (rise_we[b]) rise_d[b] = wdata;
      if (fall_we[b]) fall_d[b] = wdata;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign clr_edge = wr_en && (addr == OFF_CLEAR) && wdata[CLR_EDGE_BIT];
  assign clr_ovf  = wr_en && (addr == OFF_CLEAR) && wdata[CLR_OVF_BIT];

  assign ctrl      = ctrl_q;
  assign rise_mask = rise_q[CH-1:0];
  assign fall_mask = fall_q[CH-1:0];

  // Read decode
  always_comb begin
    rdata = 8'h00;
    if (addr == OFF_STAT) rdata = status_byte;
    if (addr == OFF_CTRL) rdata = {3'b000, ctrl_q};
    for (int b = 0; b < NBYTES; b++) begin
      if (addr == OFF_RISE + AW'(b)) rdata = rise_q[b];
      if (addr == OFF_FALL + AW'(b)) rdata = fall_q[b];
    end
  end

  // R10: a control write is held and read back on the next cycle
  p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == ctrl_t'($past(wdata[4:0]))));
endmodule

// File: rtl/edc_detect.sv
module edc_detect
  import edc_pkg::*;
#(
  parameter int CH = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] din,
  input  logic [CH-1:0] rise_mask,
  input  logic [CH-1:0] fall_mask,
  input  logic          rise_arm,
  input  logic          fall_arm,
  output logic          event_o
);
  logic [CH-1:0] prev_q, prev_d;
  logic          rise_hit, fall_hit;

  assign prev_d = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise_hit = rise_arm && |(din & ~prev_q & rise_mask);
  assign fall_hit = fall_arm && |(~din & prev_q & fall_mask);
  assign event_o  = rise_hit || fall_hit;

  // R4: with both directions disarmed nothing is detected
  p_disarmed_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_arm && !fall_arm) |-> !event_o);

  // R4: unchanged inputs never produce an event
  p_static_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (din == prev_q) |-> !event_o);
endmodule

// File: rtl/edc_status.sv
module edc_status
  import edc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  event_i,
  input  logic  clr_edge,
  input  logic  clr_ovf,
  input  ctrl_t ctrl,
  output logic  edge_o,
  output logic  ovf_o,
  output logic  master_o
);
  logic edge_q, edge_d;
  logic ovf_q, ovf_d;

  // Next-state: an event outranks a clear in the same cycle
  always_comb begin
    edge_d = event_i || (edge_q && !clr_edge);
    ovf_d  = (event_i && edge_q) || (ovf_q && !clr_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      edge_q <= edge_d;
      ovf_q  <= ovf_d;
    end
  end

  assign edge_o   = edge_q;
  assign ovf_o    = ovf_q;
  assign master_o = ctrl.master_en &&
                    ((edge_q && ctrl.edge_ie) || (ovf_q && ctrl.ovf_ie));

  // R5: overflow rises only when the edge flag was already set
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(edge_q));

  // R6: a clear without a competing event empties the edge flag
  p_clear_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !event_i) |=> !edge_q);

  // R6: a clear of overflow alone leaves edge untouched
  p_clear_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !clr_edge) |=> (edge_q || !$past(edge_q)));

  // R7: an event always leaves the edge flag set
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> edge_q);
endmodule

// File: rtl/edge_notify_ctrl.sv
module edge_notify_ctrl
  import edc_pkg::*;
#(
  parameter int CH = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] din,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq
);
  ctrl_t         ctrl;
  logic [CH-1:0] rise_mask, fall_mask;
  logic          clr_edge, clr_ovf;
  logic          evt;
  logic          edge_flag, ovf_flag, master;
  logic [7:0]    status_byte;

  assign status_byte = {5'b00000, master, ovf_flag, edge_flag};

  edc_regs #(.CH(CH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .status_byte (status_byte),
    .ctrl        (ctrl),
    .rise_mask   (rise_mask),
    .fall_mask   (fall_mask),
    .clr_edge    (clr_edge),
    .clr_ovf     (clr_ovf),
    .rdata       (rdata)
  );

  edc_detect #(.CH(CH)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .rise_mask (rise_mask),
    .fall_mask (fall_mask),
    .rise_arm  (ctrl.rise_arm),
    .fall_arm  (ctrl.fall_arm),
    .event_o   (evt)
  );

  edc_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_i  (evt),
    .clr_edge (clr_edge),
    .clr_ovf  (clr_ovf),
    .ctrl     (ctrl),
    .edge_o   (edge_flag),
    .ovf_o    (ovf_flag),
    .master_o (master)
  );

  assign irq = master;

  // R8: the interrupt line needs a pending flag and the master enable
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl.master_en && (edge_flag || ovf_flag)));

  // R9: clearing control drops the line on the next edge
  p_ctrl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CTRL && wdata == 8'h00) |=> !irq);
endmodule

// File: tb/tb_edge_notify_ctrl.sv
module tb_edge_notify_ctrl;
  localparam int CH = 24;
  localparam time CLK_PERIOD = 10ns;

  logic          clk;
  logic          rst_n;
  logic [CH-1:0] din;
  logic          wr_en;
  logic [4:0]    addr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          irq;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  edge_notify_ctrl #(.CH(CH)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic pin(input int ch, input logic v);
    din[ch] = v;
    @(negedge clk);
  endtask

  task automatic chk_stat(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    rd(5'h04, v);
    check(tag, v, exp);
    check({tag, " irq"}, {7'd0, irq}, {7'd0, exp[2]});
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk_stat("R1 status", 8'h00);
    rd(5'h05, v); check("R1 ctrl", v, 8'h00);
    for (int k = 0; k < 3; k++) begin
      rd(5'(8 + k), v);  check("R1 rise mask", v, 8'h00);
      rd(5'(12 + k), v); check("R1 fall mask", v, 8'h00);
    end
  endtask

  task automatic t_readback;
    logic [7:0] v;
    wr(5'h09, 8'h02);
    wr(5'h0E, 8'h80);
    wr(5'h05, 8'hFD);
    rd(5'h09, v); check("R10 rise byte1", v, 8'h02);
    rd(5'h08, v); check("R10 rise byte0", v, 8'h00);
    rd(5'h0E, v); check("R10 fall byte2", v, 8'h80);
    rd(5'h05, v); check("R10 ctrl", v, 8'h1D);
  endtask

  task automatic t_rise;
    wr(5'h05, 8'h0D);
    pin(9, 1'b1);
    chk_stat("R2 rising ch9", 8'h05);
    wr(5'h00, 8'h08);
    chk_stat("R6 edge cleared", 8'h00);
  endtask

  task automatic t_fall;
    wr(5'h05, 8'h15);
    pin(23, 1'b1);
    chk_stat("R3 no event on rise", 8'h00);
    pin(23, 1'b0);
    chk_stat("R3 falling ch23", 8'h05);
    wr(5'h00, 8'h08);
  endtask

  task automatic t_ignored;
    pin(0, 1'b1);
    pin(0, 1'b0);
    chk_stat("R4 unmasked channel", 8'h00);
    wr(5'h05, 8'h05);
    pin(23, 1'b1);
    pin(23, 1'b0);
    chk_stat("R4 fall disarmed", 8'h00);
  endtask

  task automatic t_overflow;
    wr(5'h05, 8'h1F);
    pin(23, 1'b1);
    pin(23, 1'b0);
    chk_stat("R5 first event", 8'h05);
    pin(23, 1'b1);
    pin(23, 1'b0);
    chk_stat("R5 overflow", 8'h07);
    wr(5'h00, 8'h08);
    chk_stat("R6 edge only cleared", 8'h06);
    wr(5'h00, 8'h04);
    chk_stat("R6 overflow cleared", 8'h00);
  endtask

  task automatic t_gating;
    wr(5'h05, 8'h16);
    pin(23, 1'b1);
    pin(23, 1'b0);
    chk_stat("R8 edge ie off", 8'h01);
    wr(5'h05, 8'h17);
    chk_stat("R8 edge ie on", 8'h05);
    wr(5'h05, 8'h00);
    chk_stat("R9 control zero", 8'h01);
    wr(5'h00, 8'h0C);
    chk_stat("R6 both cleared", 8'h00);
  endtask

  task automatic t_collide;
    wr(5'h05, 8'h15);
    pin(23, 1'b1);
    din[23] = 1'b0;
    wr(5'h00, 8'h08);
    chk_stat("R7 event beats clear", 8'h05);
    wr(5'h00, 8'h0C);
    chk_stat("R7 cleared after", 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; din = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_rise();
    t_fall();
    t_ignored();
    t_overflow();
    t_gating();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule